// File: doc/BRIEF.md
# Frequency Correction Register Interface

This block sits between a byte-wide register bus and the frequency-correction path of a receiver. It keeps the current signed 16-bit correction word, which the correction loop refreshes and software can overwrite one byte at a time. It also keeps the latest signed 16-bit frequency-error measurement, which software reads as two bytes. A control register arms an automatic clear at the start of each correction phase, clears the correction word on demand, and launches a gain-control sequence.

The error measurement is read upper byte first. That read freezes a copy of the lower byte, so the two bytes always belong to the same measurement. A small two-state machine tracks whether a frozen lower byte is pending. The states are `FEI_TRACK` (the lower byte follows the live measurement) and `FEI_HELD` (the lower byte comes from the frozen copy). An upper-byte read moves the machine from `FEI_TRACK` to `FEI_HELD`, and an upper-byte read while in `FEI_HELD` refreshes the copy. A lower-byte read moves it from `FEI_HELD` back to `FEI_TRACK`. Software converts the raw error to hertz by multiplying it by the synthesizer step.

Top module: `afcfei_regs`

## Requirements
- R1: After reset the correction word is 0, `gain_start` is 0, and every register address reads 0.
- R2: A bus write to offset 1 replaces bits 15:8 of the correction word, and a write to offset 2 replaces bits 7:0. The other byte keeps its value.
- R3: When `loop_valid` is high, `loop_value` is loaded into the correction word on the next edge. A bus byte write or a clear in the same cycle takes priority, and the loop value is then dropped entirely.
- R4: `rdata` carries the addressed byte in the cycle after `rd_en`, and 0 in any other cycle. Offsets 1 and 2 return the upper and lower correction bytes.
- R5: A `fei_valid` pulse stores `fei_meas`. Offset 3 returns the upper error byte, and a following read of offset 4 returns the lower byte of the same measurement.
- R6: A measurement that arrives between the offset 3 read and the offset 4 read does not change the byte that offset 4 returns. A read of offset 4 with no pending offset 3 read returns the live lower byte.
- R7: Writing 1 to bit 6 of offset 0 clears the correction word on the next edge, but only while `rx_mode` is 1. Otherwise the word is unchanged. Bit 6 always reads 0.
- R8: Bit 0 of offset 0 is a readable auto-clear enable. While it is 1 and `auto_afc_on` is 1, an `afc_phase_start` pulse clears the correction word. With `auto_afc_on` at 0, the pulse has no effect on the word.
- R9: Writing 1 to bit 7 of offset 0 gives a single-cycle `gain_start` pulse on the next edge. Bit 7 always reads 0.
- R10: Bits 5:1 of offset 0 and offsets 5 to 7 read 0, and writes to them change nothing. Offsets 3 and 4 ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write byte |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read byte, valid the cycle after `rd_en` |
| rx_mode | input | 1 | Receiver is in receive mode |
| auto_afc_on | input | 1 | Automatic correction is enabled |
| afc_phase_start | input | 1 | Start of an automatic correction phase |
| loop_valid | input | 1 | Correction loop offers a new word |
| loop_value | input | 16 | New correction word from the loop |
| fei_valid | input | 1 | New error measurement strobe |
| fei_meas | input | 16 | Signed error measurement |
| afc_value | output | 16 | Current signed correction word |
| gain_start | output | 1 | Gain-control sequence start pulse |

## Verification
The bench first reads the upper error byte, then lets a new measurement arrive, then reads the lower byte. A design without the frozen copy would return the new lower byte and break the pair. The bench also checks that a later lower-byte read follows the live value again, which catches a machine that never leaves `FEI_HELD`. It issues a clear outside receive mode and a phase start with automatic correction off, and a design that ignores either gate would zero the word. It collides a loop update with a single-byte bus write, and a wrong priority would show the loop word. It also confirms that the trigger bits and the unused bits read back as zero and that `gain_start` lasts exactly one cycle.

// File: rtl/afcfei_pkg.sv
package afcfei_pkg;
    typedef enum logic [0:0] {
        FEI_TRACK = 1'b0,
        FEI_HELD  = 1'b1
    } fei_state_e;

    localparam int unsigned OFS_CTRL   = 0;
    localparam int unsigned OFS_AFC_HI = 1;
    localparam int unsigned OFS_AFC_LO = 2;
    localparam int unsigned OFS_FEI_HI = 3;
    localparam int unsigned OFS_FEI_LO = 4;

    localparam int unsigned BIT_AUTOCLR = 0;
    localparam int unsigned BIT_CLR     = 6;
    localparam int unsigned BIT_GAIN    = 7;
endpackage

// File: rtl/afcfei_ctl.sv
module afcfei_ctl (
    input  logic clk,
    input  logic rst,
    input  logic ctrl_we,
    input  logic bit_autoclr,
    input  logic bit_clr,
    input  logic bit_gain,
    input  logic rx_mode,
    output logic autoclr_en,
    output logic clr_req,
    output logic gain_go
);
    // stored enable bit and registered gain pulse
    always_ff @(posedge clk) begin
        if (rst) begin
            autoclr_en <= 1'b0;
            gain_go    <= 1'b0;
        end else begin
            gain_go <= ctrl_we && bit_gain;
            if (ctrl_we) autoclr_en <= bit_autoclr;
        end
    end

    // the manual clear only acts while receiving
    always_comb clr_req = ctrl_we && bit_clr && rx_mode;
endmodule

// File: rtl/afcfei_afc_hold.sv
module afcfei_afc_hold #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic              loop_valid,
    input  logic [2*BYTE_W-1:0] loop_value,
    output logic [2*BYTE_W-1:0] afc_value
);
    localparam int unsigned VAL_W = 2 * BYTE_W;

    logic [VAL_W-1:0] afc_d;

    // priority: clear, then bus byte write, then loop update
    always_comb begin
        afc_d = afc_value;
        if (clr) begin
            afc_d = '0;
        end else if (wr_hi || wr_lo) begin
            if (wr_hi) afc_d[VAL_W-1:BYTE_W] = wbyte;
            if (wr_lo) afc_d[BYTE_W-1:0]     = wbyte;
        end else if (loop_valid) begin
            afc_d = loop_value;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) afc_value <= '0;
        else     afc_value <= afc_d;
    end
endmodule

// File: rtl/afcfei_fei_view.sv
module afcfei_fei_view
    import afcfei_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fei_valid,
    input  logic [2*BYTE_W-1:0] fei_meas,
    input  logic                rd_hi,
    input  logic                rd_lo,
    output logic [BYTE_W-1:0]   hi_byte,
    output logic [BYTE_W-1:0]   lo_byte
);
    localparam int unsigned VAL_W = 2 * BYTE_W;

    fei_state_e       state_q, state_d;
    logic [VAL_W-1:0] fei_q;
    logic [BYTE_W-1:0] snap_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= FEI_TRACK;
        else     state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FEI_TRACK: if (rd_hi) state_d = FEI_HELD;
            FEI_HELD:  if (rd_lo && !rd_hi) state_d = FEI_TRACK;
            default:   state_d = FEI_TRACK;
        endcase
    end

    // measurement and frozen lower byte
    always_ff @(posedge clk) begin
        if (rst) begin
            fei_q  <= '0;
            snap_q <= '0;
        end else begin
            if (fei_valid) fei_q  <= fei_meas;
            if (rd_hi)     snap_q <= fei_q[BYTE_W-1:0];
        end
    end

    // outputs
    always_comb begin
        hi_byte = fei_q[VAL_W-1:BYTE_W];
        unique case (state_q)
            FEI_HELD: lo_byte = snap_q;
            default:  lo_byte = fei_q[BYTE_W-1:0];
        endcase
    end
endmodule

// File: rtl/afcfei_regs.sv
module afcfei_regs
    import afcfei_pkg::*;
#(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic                wr_en,
    input  logic                rd_en,
    output logic [BYTE_W-1:0]   rdata,
    input  logic                rx_mode,
    input  logic                auto_afc_on,
    input  logic                afc_phase_start,
    input  logic                loop_valid,
    input  logic [2*BYTE_W-1:0] loop_value,
    input  logic                fei_valid,
    input  logic [2*BYTE_W-1:0] fei_meas,
    output logic [2*BYTE_W-1:0] afc_value,
    output logic                gain_start
);
    localparam int unsigned VAL_W = 2 * BYTE_W;

    logic sel_ctrl, sel_ahi, sel_alo, sel_fhi, sel_flo;
    logic autoclr_en, clr_req, auto_clr;
    logic [BYTE_W-1:0] fei_hi_byte, fei_lo_byte;
    logic [BYTE_W-1:0] rd_mux;

    always_comb begin
        sel_ctrl = (addr == ADDR_W'(OFS_CTRL));
        sel_ahi  = (addr == ADDR_W'(OFS_AFC_HI));
        sel_alo  = (addr == ADDR_W'(OFS_AFC_LO));
        sel_fhi  = (addr == ADDR_W'(OFS_FEI_HI));
        sel_flo  = (addr == ADDR_W'(OFS_FEI_LO));
    end

    afcfei_ctl u_ctl (
        .clk         (clk),
        .rst         (rst),
        .ctrl_we     (wr_en && sel_ctrl),
        .bit_autoclr (wdata[BIT_AUTOCLR]),
        .bit_clr     (wdata[BIT_CLR]),
        .bit_gain    (wdata[BIT_GAIN]),
        .rx_mode     (rx_mode),
        .autoclr_en  (autoclr_en),
        .clr_req     (clr_req),
        .gain_go     (gain_start)
    );

    // automatic clear only while automatic correction runs
    always_comb auto_clr = afc_phase_start && auto_afc_on && autoclr_en;

    afcfei_afc_hold #(.BYTE_W(BYTE_W)) u_afc (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr_req || auto_clr),
        .wr_hi      (wr_en && sel_ahi),
        .wr_lo      (wr_en && sel_alo),
        .wbyte      (wdata),
        .loop_valid (loop_valid),
        .loop_value (loop_value),
        .afc_value  (afc_value)
    );

    afcfei_fei_view #(.BYTE_W(BYTE_W)) u_fei (
        .clk       (clk),
        .rst       (rst),
        .fei_valid (fei_valid),
        .fei_meas  (fei_meas),
        .rd_hi     (rd_en && sel_fhi),
        .rd_lo     (rd_en && sel_flo),
        .hi_byte   (fei_hi_byte),
        .lo_byte   (fei_lo_byte)
    );

    // read multiplexer; trigger and unused bits return zero
    always_comb begin
        rd_mux = '0;
        if (sel_ctrl) rd_mux[BIT_AUTOCLR] = autoclr_en;
        if (sel_ahi)  rd_mux = afc_value[VAL_W-1:BYTE_W];
        if (sel_alo)  rd_mux = afc_value[BYTE_W-1:0];
        if (sel_fhi)  rd_mux = fei_hi_byte;
        if (sel_flo)  rd_mux = fei_lo_byte;
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
        else            rdata <= '0;
    end
endmodule

// File: rtl/afcfei_checker.sv
module afcfei_checker
    import afcfei_pkg::*;
#(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned BYTE_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   addr,
    input logic [BYTE_W-1:0]   wdata,
    input logic                wr_en,
    input logic                rd_en,
    input logic [BYTE_W-1:0]   rdata,
    input logic                rx_mode,
    input logic                auto_afc_on,
    input logic                afc_phase_start,
    input logic                loop_valid,
    input logic                autoclr_en,
    input logic [2*BYTE_W-1:0] afc_value,
    input logic                gain_start
);
    localparam int unsigned VAL_W = 2 * BYTE_W;

    logic ctrl_wr, auto_cond;
    always_comb begin
        ctrl_wr   = wr_en && (addr == ADDR_W'(OFS_CTRL));
        auto_cond = afc_phase_start && auto_afc_on && autoclr_en;
    end

    assert_gain_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wdata[BIT_GAIN]) |=> gain_start);

    assert_gain_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !(ctrl_wr && wdata[BIT_GAIN]) |=> !gain_start);

    assert_manual_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wdata[BIT_CLR] && rx_mode) |=> (afc_value == '0));

    assert_auto_clear_R8: assert property (@(posedge clk) disable iff (rst)
        auto_cond |=> (afc_value == '0));

    assert_phase_no_effect_R8: assert property (@(posedge clk) disable iff (rst)
        (afc_phase_start && !auto_afc_on && !wr_en && !loop_valid) |=> $stable(afc_value));

    assert_ctrl_read_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (addr == ADDR_W'(OFS_CTRL))) |=> ((rdata >> 1) == '0));

    assert_write_hi_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == ADDR_W'(OFS_AFC_HI)) && !auto_cond)
        |=> (afc_value[VAL_W-1:BYTE_W] == $past(wdata)));
endmodule

bind afcfei_regs afcfei_checker #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .addr            (addr),
    .wdata           (wdata),
    .wr_en           (wr_en),
    .rd_en           (rd_en),
    .rdata           (rdata),
    .rx_mode         (rx_mode),
    .auto_afc_on     (auto_afc_on),
    .afc_phase_start (afc_phase_start),
    .loop_valid      (loop_valid),
    .autoclr_en      (autoclr_en),
    .afc_value       (afc_value),
    .gain_start      (gain_start)
);

// File: tb/afcfei_regs_bench.sv
module afcfei_regs_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  rdata;
    logic        rx_mode = 1'b0, auto_afc_on = 1'b0, afc_phase_start = 1'b0;
    logic        loop_valid = 1'b0, fei_valid = 1'b0;
    logic [15:0] loop_value = '0, fei_meas = '0;
    logic [15:0] afc_value;
    logic        gain_start;

    int checks = 0;
    int errors = 0;
    logic [7:0]  exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #10 clk = ~clk;

    afcfei_regs u_afcfei_regs (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata), .rx_mode(rx_mode), .auto_afc_on(auto_afc_on),
        .afc_phase_start(afc_phase_start), .loop_valid(loop_valid),
        .loop_value(loop_value), .fei_valid(fei_valid), .fei_meas(fei_meas),
        .afc_value(afc_value), .gain_start(gain_start)
    );

    // monitor: compares each read result one cycle after the strobe
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rdata !== e) begin
                errors++;
                $display("FAIL %s rdata actual %h expected %h", t, rdata, e);
            end
        end
    end

    task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", t, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, input logic [7:0] e, input string t);
        @(negedge clk); addr = a; rd_en = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic loop_load(input logic [15:0] v);
        @(negedge clk); loop_value = v; loop_valid = 1'b1;
        @(negedge clk); loop_valid = 1'b0;
    endtask

    task automatic fei_load(input logic [15:0] v);
        @(negedge clk); fei_meas = v; fei_valid = 1'b1;
        @(negedge clk); fei_valid = 1'b0;
    endtask

    task automatic phase_pulse;
        @(negedge clk); afc_phase_start = 1'b1;
        @(negedge clk); afc_phase_start = 1'b0;
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 afc", afc_value, 0);
        chk("R1 gain", gain_start, 0);
        for (int i = 0; i < 8; i++) bus_rd(i[2:0], 8'h00, "R1");

        // R2 byte writes, R4 read back
        bus_wr(3'd1, 8'h12);
        chk("R2 hi", afc_value, 16'h1200);
        bus_wr(3'd2, 8'h34);
        chk("R2 lo", afc_value, 16'h1234);
        bus_rd(3'd1, 8'h12, "R4 hi");
        bus_rd(3'd2, 8'h34, "R4 lo");

        // R3 loop update and priority against a bus write
        loop_load(16'hBEEF);
        chk("R3 load", afc_value, 16'hBEEF);
        @(negedge clk);
        addr = 3'd2; wdata = 8'h55; wr_en = 1'b1;
        loop_value = 16'h1111; loop_valid = 1'b1;
        @(negedge clk); wr_en = 1'b0; loop_valid = 1'b0;
        chk("R3 priority", afc_value, 16'hBE55);

        // R5 coherent pair
        fei_load(16'hA5C3);
        bus_rd(3'd3, 8'hA5, "R5 hi");
        bus_rd(3'd4, 8'hC3, "R5 lo");

        // R6 update between the two reads
        fei_load(16'h0102);
        bus_rd(3'd3, 8'h01, "R6 hi");
        fei_load(16'h7F80);
        bus_rd(3'd4, 8'h02, "R6 frozen lo");
        bus_rd(3'd4, 8'h80, "R6 live lo");
        bus_rd(3'd3, 8'h7F, "R6 new hi");
        bus_rd(3'd4, 8'h80, "R6 new lo");

        // R7 manual clear gated by receive mode
        rx_mode = 1'b0;
        bus_wr(3'd0, 8'h40);
        chk("R7 not rx", afc_value, 16'hBE55);
        rx_mode = 1'b1;
        bus_wr(3'd0, 8'h40);
        chk("R7 rx clear", afc_value, 16'h0000);
        bus_rd(3'd0, 8'h00, "R7 readback");

        // R8 auto clear
        loop_load(16'h2222);
        bus_wr(3'd0, 8'h01);
        bus_rd(3'd0, 8'h01, "R8 enable readback");
        auto_afc_on = 1'b0;
        phase_pulse();
        chk("R8 auto off", afc_value, 16'h2222);
        auto_afc_on = 1'b1;
        phase_pulse();
        chk("R8 auto clear", afc_value, 16'h0000);
        bus_wr(3'd0, 8'h00);
        loop_load(16'h3333);
        phase_pulse();
        chk("R8 enable off", afc_value, 16'h3333);

        // R9 gain start pulse
        bus_wr(3'd0, 8'h80);
        chk("R9 pulse", gain_start, 1);
        @(negedge clk);
        chk("R9 single", gain_start, 0);
        bus_rd(3'd0, 8'h00, "R9 readback");

        // R10 unused bits and addresses
        bus_wr(3'd0, 8'h3E);
        bus_rd(3'd0, 8'h00, "R10 ctrl bits");
        bus_wr(3'd5, 8'hFF);
        bus_wr(3'd7, 8'hFF);
        bus_wr(3'd3, 8'hFF);
        bus_wr(3'd4, 8'hFF);
        bus_rd(3'd5, 8'h00, "R10 off5");
        bus_rd(3'd7, 8'h00, "R10 off7");
        chk("R10 afc kept", afc_value, 16'h3333);
        bus_rd(3'd3, 8'h7F, "R10 fei hi");
        bus_rd(3'd4, 8'h80, "R10 fei lo");

        repeat (3) @(negedge clk);
        chk("queue drained", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule